// File: doc/BRIEF.md
# Grouped Shared Interrupt Combiner

This block gathers 22 peripheral interrupt sources into one pending word and splits that word into four fixed bit ranges. Each range drives its own parent interrupt line toward the next level of interrupt logic. A rising edge on a source records a sticky pending bit. The pending bit stays set until software clears it through a small register port. That port has an address, a write strobe, write data and read data that is valid in the same cycle.

One register offset serves both purposes. A read returns the raw pending bits, and a write clears every bit position where the written value holds a zero. Only the lowest range, sources 0 to 6, has a mask register, and in that register a zero means the source is enabled. The other three ranges are always live. Software clears a single source with a read-modify-write: it writes back all ones except a zero at the bit to be cleared.

Top module: `irq_group_combiner`

## Requirements
- R1: Each group drives its own bit of `irq_o`, and that bit is set whenever a pending bit in the group's range is set and enabled. The groups and their bits are: `irq_o[0]` for status bits 0..6, `irq_o[1]` for bits 7..9, `irq_o[2]` for bit 10, and `irq_o[3]` for bits 11..21.
- R2: A 0-to-1 transition on `src_i[k]`, seen at a clock edge, sets pending bit k. The bit stays set until it is cleared. A source held high after its bit is cleared does not set the bit again.
- R3: A read at offset 0x04 returns the raw pending bits in bits 21..0, whatever the mask state, and returns zero in bits 31..22.
- R4: A write at offset 0x04 clears every pending bit whose written data bit is 0. A written 1 leaves the bit as it was.
- R5: If a rising edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The mask register at offset 0x08 holds bits 6..0. A 0 enables the matching source of group 0, and a 1 masks it. At reset the register is 0x7F, so group 0 starts fully masked.
- R7: Bits 31..7 of the mask register read as zero, and writes to those bits are ignored.
- R8: Groups 1 to 3 have no mask. Their pending bits always reach `irq_o`.
- R9: `irq_o` is a registered level. A group output changes one clock after the edge that changes its pending or mask state, and it drops one cycle after the last enabled pending bit is cleared or masked.
- R10: Reads of any offset other than 0x04 and 0x08 return zero, and writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 22 | Peripheral interrupt sources, edge-detected |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, same cycle |
| irq_o | output | 4 | One parent interrupt line per group |

## Verification
The assertions check several properties on every cycle. Unused read bits stay zero. Pending bits never drop without a clearing write, and a write of all ones never drops them. A fully masked group 0 stays silent. The outputs of groups 1 and 3 follow their pending bits one cycle later. Other behaviour is only visible in the directed scenarios: the mapping of each source to its group, the one-cycle delay of `irq_o` after a clear or a mask, the set-wins collision, the held-high source that does not re-trigger, and unmapped offsets that do nothing.

// File: rtl/irq_group_combiner.sv
module irq_group_combiner #(
  parameter int G0_W   = 7,
  parameter int G1_W   = 3,
  parameter int G2_W   = 1,
  parameter int G3_W   = 11,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h08
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [G0_W+G1_W+G2_W+G3_W-1:0]      src_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic                                wr_en_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic [3:0]                          irq_o
);
  localparam int N_SRC = G0_W + G1_W + G2_W + G3_W;
  localparam int N_GRP = 4;
  localparam int GRP_LO [N_GRP] = '{0, G0_W, G0_W + G1_W, G0_W + G1_W + G2_W};
  localparam int GRP_WD [N_GRP] = '{G0_W, G1_W, G2_W, G3_W};

  logic [N_SRC-1:0] src_q, pend_q, clr, rise, live;
  logic [G0_W-1:0]  mask_q;
  logic [N_GRP-1:0] irq_q;

  wire stat_wr = wr_en_i && (addr_i == STAT_OFS);
  wire mask_wr = wr_en_i && (addr_i == MASK_OFS);

  assign rise = src_i & ~src_q;
  assign clr  = stat_wr ? ~wdata_i[N_SRC-1:0] : '0;
  assign live = pend_q & {{(N_SRC-G0_W){1'b1}}, ~mask_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr) | rise;
      if (mask_wr) mask_q <= wdata_i[G0_W-1:0];
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int LO = GRP_LO[g];
    localparam int WD = GRP_WD[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= |live[LO +: WD];
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_OFS)      rdata_o[N_SRC-1:0] = pend_q;
    else if (addr_i == MASK_OFS) rdata_o[G0_W-1:0]  = mask_q;
  end
endmodule

// File: rtl/irq_group_combiner_chk.sv
module irq_group_combiner_chk #(
  parameter int N_SRC  = 22,
  parameter int G0_W   = 7,
  parameter int G1_W   = 3,
  parameter int G3_W   = 11,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [3:0]        irq_o,
  input logic [N_SRC-1:0]  pend_q,
  input logic [G0_W-1:0]   mask_q
);
  p_stat_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == STAT_OFS) |-> (rdata_o[DATA_W-1:N_SRC] == '0));

  p_mask_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == MASK_OFS) |-> (rdata_o[DATA_W-1:G0_W] == '0));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == STAT_OFS) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_ones_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == STAT_OFS && (&wdata_i[N_SRC-1:0]))
      |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_o[0]);

  p_grp1_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[1] == $past(|pend_q[G0_W+G1_W-1:G0_W])));

  p_grp3_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[3] == $past(|pend_q[N_SRC-1:N_SRC-G3_W])));
endmodule

bind irq_group_combiner irq_group_combiner_chk #(
  .N_SRC(N_SRC), .G0_W(G0_W), .G1_W(G1_W), .G3_W(G3_W),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/irq_group_combiner_tb.sv
module irq_group_combiner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STAT = 8'h04;
  localparam logic [7:0] MASK = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_group_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; wr = 1'b0;
    #1 d = rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); src[k] = 1'b1;
    @(negedge clk); src[k] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R9 irq after reset", {28'd0, irq}, 32'd0);
    bus_rd(STAT, v); chk("R3 status after reset", v, 32'd0);
    bus_rd(MASK, v); chk("R6 mask reset value", v, 32'h7F);
  endtask

  task automatic t_groups;
    int idx [4] = '{7, 10, 11, 21};
    int grp [4] = '{1, 2, 3, 3};
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      pulse(idx[i]);
      @(negedge clk);
      chk("R1/R8 group line", {28'd0, irq}, 32'd1 << grp[i]);
      bus_rd(STAT, v); chk("R2 pending captured", v, 32'd1 << idx[i]);
      bus_wr(STAT, ~(32'd1 << idx[i]));
      chk("R9 line still up on clear edge", {28'd0, irq}, 32'd1 << grp[i]);
      @(negedge clk);
      chk("R9 line drops after clear", {28'd0, irq}, 32'd0);
    end
  endtask

  task automatic t_mask;
    logic [31:0] v;
    pulse(3);
    @(negedge clk);
    chk("R6 masked source silent", {28'd0, irq}, 32'd0);
    bus_rd(STAT, v); chk("R3 raw status while masked", v, 32'h8);
    bus_wr(MASK, 32'h77);
    chk("R9 no change on mask edge", {28'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R6 zero enables", {28'd0, irq}, 32'd1);
    bus_wr(MASK, 32'h7F);
    @(negedge clk);
    chk("R9 drop after mask", {28'd0, irq}, 32'd0);
    bus_wr(MASK, 32'hFFFF_FF80);
    bus_rd(MASK, v); chk("R7 upper mask bits ignored", v, 32'd0);
    bus_wr(MASK, 32'h7F);
    bus_rd(MASK, v); chk("R7 mask readback", v, 32'h7F);
  endtask

  task automatic t_write_one;
    logic [31:0] v;
    pulse(12);
    bus_wr(STAT, 32'hFFFF_FFFF);
    bus_rd(STAT, v); chk("R4 writing ones keeps pending", v, 32'h1008);
    bus_wr(STAT, ~32'h1000);
    bus_rd(STAT, v); chk("R4 single-bit clear", v, 32'h8);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    @(negedge clk); src[5] = 1'b1; addr = STAT; wdata = 32'd0; wr = 1'b1;
    @(negedge clk); wr = 1'b0; src[5] = 1'b0;
    bus_rd(STAT, v); chk("R5 set beats clear", v, 32'h20);
    bus_wr(STAT, 32'd0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); src[15] = 1'b1;
    @(negedge clk);
    bus_rd(STAT, v); chk("R2 edge sets pending", v, 32'h8000);
    bus_wr(STAT, 32'd0);
    @(negedge clk);
    bus_rd(STAT, v); chk("R2 held level no re-set", v, 32'd0);
    src[15] = 1'b0;
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    pulse(1);
    bus_wr(8'h00, 32'd0);
    bus_wr(8'h0C, 32'd0);
    bus_rd(STAT, v); chk("R10 unmapped write ignored", v, 32'h2);
    bus_rd(MASK, v); chk("R10 mask untouched", v, 32'h7F);
    bus_rd(8'h00, v); chk("R10 unmapped read zero", v, 32'd0);
    bus_rd(8'h0C, v); chk("R10 unmapped read zero", v, 32'd0);
    bus_wr(STAT, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_groups();
    t_mask();
    t_write_one();
    t_set_wins();
    t_level();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule